// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, organised as three banks of 32, and turns them into two processor requests: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each line has a configuration word that sends it to one of the two classes and gives it a 6-bit priority. When a class has an unmasked pending line and is armed, its output rises and the number of the winning line is latched as that class's vector. The winning line is the one with the smallest priority value. On a tie, the higher line number wins. The output then stays high until software re-arms the class.

Software reaches the block through a 4 KB word-addressed register window. Each bank has a mask that can be loaded whole or changed one bit at a time through separate clear and set registers. Each bank also has software-interrupt bits with their own set and clear registers. Read-only views show the raw line levels and the pending bits of each class after masking. Global registers hold a global mask that silences both outputs, the re-arm strobes, two idle-configuration fields and a soft reset.

Top module: `sric_ctrl`

## Requirements
- R1: After reset both outputs are low and both vectors read 0. Every bank mask reads 0xFFFFFFFF. Word 0x00 reads 0x21 and word 0x14 reads 1.
- R2: A line going high sets its raw bit (bank word +0x00) and its pending bit in the same clock. A line going low clears its raw bit and reloads that bank's pending bits with raw OR software bits.
- R3: Bank word +0x04 loads the mask. Word +0x08 clears the written mask bits and word +0x0C sets them. Both of these words read 0.
- R4: Writing bank word +0x10 ORs the value into both the software bits and the pending bits; reading +0x10 returns the software bits. Writing bank word +0x14 clears the written software bits and reloads pending as software AND raw.
- R5: Bank word +0x18 reads pending AND NOT mask AND NOT FIQ-select. Bank word +0x1C reads pending AND NOT mask AND FIQ-select. Bank b sits at byte 0x80 + 0x20*b.
- R6: Byte 0x100 + 4*L is line L's configuration word: bit 0 selects FIQ and bits 7:2 hold the priority. It reads back exactly as written in those bits.
- R7: An armed class whose unmasked request set is non-empty raises its output one clock after the request becomes visible, provided the global mask is clear. It latches the vector and disarms.
- R8: The latched vector is the requesting line with the lowest priority value. Ties go to the highest line number.
- R9: Writing control word 0x48 with bit 0 (IRQ) or bit 1 (FIQ) deasserts that output on the next clock and re-arms it. While an output stays high, its vector (0x40 for IRQ, 0x44 for FIQ) is stable, and reading it clears nothing.
- R10: Control bit 2 is the global mask and reads back in bit 2. One clock after it is set, both outputs are low. A class whose output it drops is re-armed.
- R11: Bit 0 of word 0x10 (autoidle) and bits 1:0 of word 0x50 are read/write. The protection word 0x4C reads 0 and ignores writes.
- R12: Writing bit 1 of word 0x10 returns all bank, configuration and global state to reset values in one clock.
- R13: Bank slot 3 (bytes 0xE0-0xFF) and configuration words of lines 96 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | 96 | Interrupt lines, active high, level sensitive |
| bus_sel | input | 1 | Register access strobe, one clock per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | IRQ request |
| fiq_o | output | 1 | FIQ request |

## Verification
The assertions assume that a register access lasts exactly one clock, so at most one write strobe (re-arm, soft reset or mask change) is seen in any cycle. They also assume that line inputs are synchronous to `clk`. The bench drives every access from the falling edge for a single cycle, and it changes lines only on the falling edge with no access in flight. Random line toggles, mask updates and software updates are sparse, and priorities are drawn from a narrow range so that ties occur often. Vectors are checked only after an explicit re-arm, so the value under test is always freshly resolved.

// File: rtl/sric_pkg.sv
package sric_pkg;
  localparam int BANK_W = 32;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WIDX_W = ADDR_W - 2;

  typedef enum logic [2:0] {
    BOP_NONE,
    BOP_MASK_LOAD,
    BOP_MASK_CLR,
    BOP_MASK_SET,
    BOP_SW_SET,
    BOP_SW_CLR
  } bank_op_e;

  // word indices of global registers
  localparam logic [WIDX_W-1:0] WI_REV     = 10'h000;
  localparam logic [WIDX_W-1:0] WI_SYSCFG  = 10'h004;
  localparam logic [WIDX_W-1:0] WI_STAT    = 10'h005;
  localparam logic [WIDX_W-1:0] WI_VEC_IRQ = 10'h010;
  localparam logic [WIDX_W-1:0] WI_VEC_FIQ = 10'h011;
  localparam logic [WIDX_W-1:0] WI_CTRL    = 10'h012;
  localparam logic [WIDX_W-1:0] WI_PROT    = 10'h013;
  localparam logic [WIDX_W-1:0] WI_IDLE    = 10'h014;
  localparam logic [WIDX_W-1:0] WI_CFG0    = 10'h040;
  localparam logic [4:0]        WI_BANK_HI = 5'h01;

  // register index inside a bank slot
  localparam logic [2:0] BR_RAW  = 3'd0;
  localparam logic [2:0] BR_MASK = 3'd1;
  localparam logic [2:0] BR_MCLR = 3'd2;
  localparam logic [2:0] BR_MSET = 3'd3;
  localparam logic [2:0] BR_SSET = 3'd4;
  localparam logic [2:0] BR_SCLR = 3'd5;
  localparam logic [2:0] BR_PIRQ = 3'd6;
  localparam logic [2:0] BR_PFIQ = 3'd7;
endpackage

// File: rtl/sric_bank.sv
module sric_bank
  import sric_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] lines_i,
  input  bank_op_e     op_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] swi_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] raw_q, pend_q, swi_q, mask_q;
  logic [W-1:0] raw_d, pend_d, swi_d, mask_d;
  logic [W-1:0] rise, fall;

  always_comb begin
    rise   = lines_i & ~raw_q;
    fall   = raw_q & ~lines_i;
    raw_d  = lines_i;
    swi_d  = swi_q;
    mask_d = mask_q;
    // a falling line rebuilds the bank's pending set from levels and software
    pend_d = ((|fall) ? (lines_i | swi_q) : pend_q) | rise;
    case (op_i)
      BOP_MASK_LOAD: mask_d = val_i;
      BOP_MASK_CLR:  mask_d = mask_q & ~val_i;
      BOP_MASK_SET:  mask_d = mask_q | val_i;
      BOP_SW_SET: begin
        swi_d  = swi_q | val_i;
        pend_d = pend_d | val_i;
      end
      BOP_SW_CLR: begin
        swi_d  = swi_q & ~val_i;
        pend_d = swi_d & lines_i;
      end
      default: ;
    endcase
    if (clr) begin
      raw_d  = '0;
      pend_d = '0;
      swi_d  = '0;
      mask_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= '0;
      swi_q  <= '0;
      mask_q <= '1;
    end else begin
      raw_q  <= raw_d;
      pend_q <= pend_d;
      swi_q  <= swi_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign pend_o = pend_q;
  assign swi_o  = swi_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/sric_resolve.sv
module sric_resolve #(
  parameter int N  = 96,
  parameter int PW = 6,
  localparam int IW = $clog2(N),
  localparam int LV = 1 << IW
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] pri_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);
  // heap-ordered tournament tree: node i has children 2i and 2i+1
  logic          tv [2*LV];
  logic [PW-1:0] tp [2*LV];
  logic [IW-1:0] ti [2*LV];

  always_comb begin
    tv[0] = 1'b0;
    tp[0] = '0;
    ti[0] = '0;
    for (int k = 0; k < LV; k++) begin
      if (k < N) begin
        tv[LV+k] = req_i[k];
        tp[LV+k] = pri_i[k*PW +: PW];
      end else begin
        tv[LV+k] = 1'b0;
        tp[LV+k] = '0;
      end
      ti[LV+k] = IW'(k);
    end
    for (int i = LV - 1; i >= 1; i--) begin
      // right child holds higher line numbers, so it wins ties
      if (tv[2*i+1] && (!tv[2*i] || (tp[2*i+1] <= tp[2*i]))) begin
        tp[i] = tp[2*i+1];
        ti[i] = ti[2*i+1];
      end else begin
        tp[i] = tp[2*i];
        ti[i] = ti[2*i];
      end
      tv[i] = tv[2*i] | tv[2*i+1];
    end
  end

  assign any_o = tv[1];
  assign idx_o = ti[1];
endmodule

// File: rtl/sric_agree.sv
module sric_agree #(
  parameter int VW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          gmask,
  input  logic          rearm,
  input  logic          req_any,
  input  logic [VW-1:0] win_i,
  output logic          out_o,
  output logic [VW-1:0] vec_o
);
  logic          armed_q, armed_d, out_q, out_d, vec_en;
  logic [VW-1:0] vec_q, vec_d;

  always_comb begin
    armed_d = armed_q;
    out_d   = out_q;
    vec_en  = 1'b0;
    vec_d   = win_i;
    if (clr) begin
      armed_d = 1'b1;
      out_d   = 1'b0;
      vec_en  = 1'b1;
      vec_d   = '0;
    end else if (rearm) begin
      armed_d = 1'b1;
      out_d   = 1'b0;
    end else if (gmask) begin
      if (out_q) begin
        armed_d = 1'b1;
        out_d   = 1'b0;
      end
    end else if (armed_q && req_any) begin
      armed_d = 1'b0;
      out_d   = 1'b1;
      vec_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      out_q   <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign out_o = out_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/sric_ctrl.sv
module sric_ctrl
  import sric_pkg::*;
#(
  parameter int          NBANKS = 3,
  parameter int          PW     = 6,
  parameter logic [7:0]  REV    = 8'h21,
  localparam int         NL     = NBANKS * BANK_W,
  localparam int         VW     = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NL-1:0]     lines_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  // reset: asynchronous assertion, release aligned to clk
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // address decode
  logic [WIDX_W-1:0] wi, cfg_off;
  logic              wr_en, rd_en, bank_hit, cfg_hit, soft_rst;
  logic [1:0]        slot, rearm_c;
  logic [2:0]        breg;
  logic [VW-1:0]     cfg_line;
  bank_op_e          bop;
  logic              unused_addr;

  assign wi          = bus_addr[ADDR_W-1:2];
  assign unused_addr = |bus_addr[1:0];
  assign wr_en       = bus_sel & bus_wr;
  assign rd_en       = bus_sel & ~bus_wr;
  assign bank_hit    = (wi[WIDX_W-1:5] == WI_BANK_HI);
  assign slot        = wi[4:3];
  assign breg        = wi[2:0];
  assign cfg_off     = wi - WI_CFG0;
  assign cfg_hit     = (wi >= WI_CFG0) && (cfg_off < WIDX_W'(NL));
  assign cfg_line    = cfg_off[VW-1:0];
  assign soft_rst    = wr_en && (wi == WI_SYSCFG) && bus_wdata[1];
  assign rearm_c     = (wr_en && (wi == WI_CTRL)) ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    case (breg)
      BR_MASK: bop = BOP_MASK_LOAD;
      BR_MCLR: bop = BOP_MASK_CLR;
      BR_MSET: bop = BOP_MASK_SET;
      BR_SSET: bop = BOP_SW_SET;
      BR_SCLR: bop = BOP_SW_CLR;
      default: bop = BOP_NONE;
    endcase
  end

  // banks
  logic [BANK_W-1:0] raw_b [NBANKS];
  logic [BANK_W-1:0] pend_b[NBANKS];
  logic [BANK_W-1:0] swi_b [NBANKS];
  logic [BANK_W-1:0] mask_b[NBANKS];
  logic [NL-1:0]     pend_all, mask_all;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    bank_op_e op_b;
    assign op_b = (wr_en && bank_hit && (slot == 2'(b))) ? bop : BOP_NONE;
    sric_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .clr    (soft_rst),
      .lines_i(lines_i[b*BANK_W +: BANK_W]),
      .op_i   (op_b),
      .val_i  (bus_wdata),
      .raw_o  (raw_b[b]),
      .pend_o (pend_b[b]),
      .swi_o  (swi_b[b]),
      .mask_o (mask_b[b])
    );
    assign pend_all[b*BANK_W +: BANK_W] = pend_b[b];
    assign mask_all[b*BANK_W +: BANK_W] = mask_b[b];
  end

  // per-line configuration
  logic [NL-1:0] fsel_q, fsel_d;
  logic [PW-1:0] prio_q [NL];
  logic [PW-1:0] prio_d [NL];
  logic [NL*PW-1:0] prio_flat;
  logic          cfg_en;

  always_comb begin
    fsel_d = fsel_q;
    prio_d = prio_q;
    cfg_en = soft_rst | (wr_en & cfg_hit);
    if (soft_rst) begin
      fsel_d = '0;
      for (int l = 0; l < NL; l++) prio_d[l] = '0;
    end else if (wr_en && cfg_hit) begin
      fsel_d[cfg_line] = bus_wdata[0];
      prio_d[cfg_line] = bus_wdata[PW+1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      for (int l = 0; l < NL; l++) prio_q[l] <= '0;
    end else if (!rst_int_n) begin
      fsel_q <= '0;
      for (int l = 0; l < NL; l++) prio_q[l] <= '0;
    end else if (cfg_en) begin
      fsel_q <= fsel_d;
      prio_q <= prio_d;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_pflat
    assign prio_flat[l*PW +: PW] = prio_q[l];
  end

  // global registers
  logic       autoidle_q, autoidle_d, gmask_q, gmask_d;
  logic [1:0] idle_q, idle_d;

  always_comb begin
    autoidle_d = autoidle_q;
    gmask_d    = gmask_q;
    idle_d     = idle_q;
    if (soft_rst) begin
      autoidle_d = 1'b0;
      gmask_d    = 1'b0;
      idle_d     = 2'b00;
    end else if (wr_en) begin
      if (wi == WI_SYSCFG) autoidle_d = bus_wdata[0];
      if (wi == WI_CTRL)   gmask_d    = bus_wdata[2];
      if (wi == WI_IDLE)   idle_d     = bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      autoidle_q <= 1'b0;
      gmask_q    <= 1'b0;
      idle_q     <= 2'b00;
    end else begin
      autoidle_q <= autoidle_d;
      gmask_q    <= gmask_d;
      idle_q     <= idle_d;
    end
  end

  // class 0 = IRQ, class 1 = FIQ
  logic          out_c [2];
  logic [VW-1:0] vec_c [2];
  logic [VW-1:0] vec_irq, vec_fiq;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [NL-1:0] req;
    logic          any;
    logic [VW-1:0] win;
    assign req = pend_all & ~mask_all & ((c == 1) ? fsel_q : ~fsel_q);
    sric_resolve #(.N(NL), .PW(PW)) u_res (
      .req_i(req),
      .pri_i(prio_flat),
      .any_o(any),
      .idx_o(win)
    );
    sric_agree #(.VW(VW)) u_agr (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .clr    (soft_rst),
      .gmask  (gmask_q),
      .rearm  (rearm_c[c]),
      .req_any(any),
      .win_i  (win),
      .out_o  (out_c[c]),
      .vec_o  (vec_c[c])
    );
  end

  assign irq_o   = out_c[0];
  assign fiq_o   = out_c[1];
  assign vec_irq = vec_c[0];
  assign vec_fiq = vec_c[1];

  // read path
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (wi)
        WI_REV:     bus_rdata = DATA_W'(REV);
        WI_SYSCFG:  bus_rdata = DATA_W'(autoidle_q);
        WI_STAT:    bus_rdata = 32'd1;
        WI_VEC_IRQ: bus_rdata = DATA_W'(vec_irq);
        WI_VEC_FIQ: bus_rdata = DATA_W'(vec_fiq);
        WI_CTRL:    bus_rdata = {29'd0, gmask_q, 2'b00};
        WI_PROT:    bus_rdata = '0;
        WI_IDLE:    bus_rdata = {30'd0, idle_q};
        default: begin
          if (bank_hit) begin
            for (int b = 0; b < NBANKS; b++) begin
              if (slot == 2'(b)) begin
                case (breg)
                  BR_RAW:  bus_rdata = raw_b[b];
                  BR_MASK: bus_rdata = mask_b[b];
                  BR_SSET: bus_rdata = swi_b[b];
                  BR_PIRQ: bus_rdata = pend_b[b] & ~mask_b[b] & ~fsel_q[b*BANK_W +: BANK_W];
                  BR_PFIQ: bus_rdata = pend_b[b] & ~mask_b[b] & fsel_q[b*BANK_W +: BANK_W];
                  default: bus_rdata = '0;
                endcase
              end
            end
          end else if (cfg_hit) begin
            bus_rdata = {{(DATA_W-PW-2){1'b0}}, prio_q[cfg_line], 1'b0, fsel_q[cfg_line]};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sric_checker.sv
module sric_checker #(
  parameter int NB = 3,
  localparam int VW = $clog2(NB * 32)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_o,
  input logic           fiq_o,
  input logic           gmask,
  input logic [1:0]     rearm,
  input logic           soft_rst,
  input logic [VW-1:0]  vec_irq,
  input logic [VW-1:0]  vec_fiq,
  input logic [NB*32-1:0] mask_all
);
  assert_gmask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> (!irq_o && !fiq_o));

  assert_fire_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(!gmask));

  assert_fiq_fire_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(!gmask));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rearm[0] && !gmask && !soft_rst) |=> irq_o);

  assert_irq_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(irq_o)) |-> $stable(vec_irq));

  assert_fiq_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && $past(fiq_o)) |-> $stable(vec_fiq));

  assert_rearm_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm[0] |=> !irq_o);

  assert_rearm_fiq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm[1] |=> !fiq_o);

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((&mask_all) && !irq_o && !fiq_o));
endmodule

bind sric_ctrl sric_checker #(.NB(NBANKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .gmask   (gmask_q),
  .rearm   (rearm_c),
  .soft_rst(soft_rst),
  .vec_irq (vec_irq),
  .vec_fiq (vec_fiq),
  .mask_all(mask_all)
);

// File: tb/tb_sric_ctrl.sv
module tb_sric_ctrl;
  localparam int NL = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NL-1:0] lines;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [NL-1:0] m_raw, m_pend, m_swi, m_mask, m_fsel;
  logic [5:0]    m_pri [NL];

  always #5 clk = ~clk;

  sric_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lines_i(lines),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  function automatic logic [11:0] ba(input int b, input int off);
    return 12'(12'h080 + b * 32 + off);
  endfunction

  function automatic void m_reset();
    m_raw = '0; m_pend = '0; m_swi = '0; m_mask = '1; m_fsel = '0;
    for (int l = 0; l < NL; l++) m_pri[l] = '0;
  endfunction

  task automatic set_lines(input logic [NL-1:0] nv);
    @(negedge clk);
    lines = nv;
    @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      logic [31:0] r, n, rise, fall, p;
      r = m_raw[b*32 +: 32]; n = nv[b*32 +: 32];
      rise = n & ~r; fall = r & ~n;
      p = (|fall) ? (n | m_swi[b*32 +: 32]) : m_pend[b*32 +: 32];
      m_pend[b*32 +: 32] = p | rise;
    end
    m_raw = nv;
  endtask

  task automatic bank_op(input int b, input int op, input logic [31:0] v);
    case (op)
      0: begin wr(ba(b, 4), v);  m_mask[b*32 +: 32] = v; end
      1: begin wr(ba(b, 8), v);  m_mask[b*32 +: 32] &= ~v; end
      2: begin wr(ba(b, 12), v); m_mask[b*32 +: 32] |= v; end
      3: begin
        wr(ba(b, 16), v);
        m_swi[b*32 +: 32] |= v; m_pend[b*32 +: 32] |= v;
      end
      default: begin
        wr(ba(b, 20), v);
        m_swi[b*32 +: 32] &= ~v;
        m_pend[b*32 +: 32] = m_swi[b*32 +: 32] & m_raw[b*32 +: 32];
      end
    endcase
  endtask

  task automatic cfg(input int l, input logic fq, input logic [5:0] p);
    wr(12'(12'h100 + 4 * l), {24'd0, p, 1'b0, fq});
    m_fsel[l] = fq; m_pri[l] = p;
  endtask

  function automatic int winner(input logic fq);
    int best = -1;
    for (int i = 0; i < NL; i++)
      if (m_pend[i] && !m_mask[i] && (m_fsel[i] == fq))
        if (best < 0 || m_pri[i] <= m_pri[best]) best = i;
    return best;
  endfunction

  task automatic check_banks(input int b);
    logic [31:0] pd, mk, fs;
    pd = m_pend[b*32 +: 32]; mk = m_mask[b*32 +: 32]; fs = m_fsel[b*32 +: 32];
    rchk("R2 raw view", ba(b, 0), m_raw[b*32 +: 32]);
    rchk("R3 mask view", ba(b, 4), mk);
    rchk("R4 software view", ba(b, 16), m_swi[b*32 +: 32]);
    rchk("R5 pending irq view", ba(b, 24), pd & ~mk & ~fs);
    rchk("R5 pending fiq view", ba(b, 28), pd & ~mk & fs);
  endtask

  // rearm both classes and compare outputs and vectors with the model (R7, R8)
  task automatic rearm_check();
    int wi, wf;
    wr(12'h048, 32'h3);
    tick(1);
    wi = winner(1'b0); wf = winner(1'b1);
    chk("R7 irq level", 32'(irq_o), 32'(wi >= 0));
    chk("R7 fiq level", 32'(fiq_o), 32'(wf >= 0));
    if (wi >= 0) rchk("R8 irq vector", 12'h040, 32'(wi));
    if (wf >= 0) rchk("R8 fiq vector", 12'h044, 32'(wf));
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d0, d1;
    void'($urandom(32'd1234));
    rst_n = 1'b0; lines = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_reset();
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    rchk("R1 revision", 12'h000, 32'h21);
    rchk("R1 status", 12'h014, 32'h1);
    for (int b = 0; b < 3; b++) rchk("R1 mask reset", ba(b, 4), 32'hFFFF_FFFF);
    rchk("R1 irq vector", 12'h040, 32'h0);
    chk("R1 irq low", 32'(irq_o), 32'h0);
    chk("R1 fiq low", 32'(fiq_o), 32'h0);

    // R13 unimplemented slot and lines
    wr(12'h0E4, 32'h0);
    rchk("R13 slot3 mask", 12'h0E4, 32'h0);
    rchk("R13 slot3 raw", 12'h0E0, 32'h0);
    wr(12'h280, 32'hFF);
    rchk("R13 line96 cfg", 12'h280, 32'h0);

    // R6 configuration readback
    cfg(95, 1'b1, 6'd1);
    rchk("R6 line95 cfg", 12'h27C, 32'h5);
    cfg(7, 1'b0, 6'h3F);
    rchk("R6 line7 cfg", 12'h11C, 32'hFC);

    // R11 idle fields and protection
    wr(12'h010, 32'h1);
    rchk("R11 autoidle", 12'h010, 32'h1);
    wr(12'h050, 32'h3);
    rchk("R11 idle bits", 12'h050, 32'h3);
    wr(12'h04C, 32'h1);
    rchk("R11 protection", 12'h04C, 32'h0);

    // R7/R8 directed: tie at equal priority goes to higher line
    cfg(3, 1'b0, 6'd2);
    cfg(10, 1'b0, 6'd2);
    cfg(40, 1'b1, 6'd1);
    bank_op(0, 1, 32'hFFFF_FFFF);
    bank_op(1, 1, 32'hFFFF_FFFF);
    set_lines(NL'((96'd1 << 3) | (96'd1 << 10)));
    check_banks(0);
    tick(1);
    chk("R7 irq asserted", 32'(irq_o), 32'h1);
    rchk("R8 tie to higher line", 12'h040, 32'd10);
    set_lines(lines | (96'd1 << 40));
    tick(1);
    chk("R7 fiq asserted", 32'(fiq_o), 32'h1);
    rchk("R8 fiq vector", 12'h044, 32'd40);

    // R9 vector reads clear nothing, held until rearm
    cfg(5, 1'b0, 6'd0);
    set_lines(lines | (96'd1 << 5));
    rd(12'h040, d0);
    rd(12'h040, d1);
    chk("R9 vector held", d1, 32'd10);
    chk("R9 irq still high", 32'(irq_o), 32'h1);
    wr(12'h048, 32'h1);
    chk("R9 irq dropped after rearm", 32'(irq_o), 32'h0);
    tick(1);
    chk("R9 irq back after rearm", 32'(irq_o), 32'h1);
    rchk("R8 lower value wins", 12'h040, 32'd5);

    // R2 falling line reloads pending
    set_lines(lines & ~(96'd1 << 10));
    check_banks(0);

    // R4 software set and clear
    bank_op(0, 3, 32'h0010_0000);
    check_banks(0);
    bank_op(0, 4, 32'h0010_0000);
    rchk("R4 pending after sw clear", ba(0, 24), 32'h0);
    set_lines(lines & ~(96'd1 << 3));
    rchk("R2 reload from raw", ba(0, 24), 32'h20);

    // R3 mask set/clear
    bank_op(1, 0, 32'h0F0F);
    bank_op(1, 1, 32'h000F);
    rchk("R3 mask after clear", ba(1, 4), 32'hFFFF_0F00 & 32'h0F00);
    bank_op(1, 2, 32'hF000);
    rchk("R3 mask after set", ba(1, 4), 32'hFF00);
    rchk("R3 clear reads zero", ba(1, 8), 32'h0);
    rchk("R3 set reads zero", ba(1, 12), 32'h0);
    bank_op(1, 0, 32'h0);

    // R10 global mask
    rearm_check();
    wr(12'h048, 32'h5);
    tick(1);
    chk("R10 irq silenced", 32'(irq_o), 32'h0);
    chk("R10 fiq silenced", 32'(fiq_o), 32'h0);
    rchk("R10 readback", 12'h048, 32'h4);
    wr(12'h048, 32'h0);
    tick(1);
    chk("R10 irq returns", 32'(irq_o), 32'h1);
    chk("R10 fiq returns", 32'(fiq_o), 32'h1);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int b, op;
      logic [31:0] v;
      b  = int'($urandom % 3);
      op = int'($urandom % 7);
      v  = $urandom & $urandom & $urandom;
      case (op)
        0: set_lines(lines ^ {v, $urandom & $urandom & $urandom, $urandom & $urandom & $urandom});
        1, 2, 3, 4: bank_op(b, int'($urandom % 5), v);
        5: cfg(int'($urandom % NL), 1'($urandom), 6'($urandom % 4));
        default: bank_op(b, 1, $urandom);
      endcase
      check_banks(b);
      if (it % 8 == 7) rearm_check();
    end

    // R12 soft reset
    set_lines('0);
    wr(12'h010, 32'h2);
    m_reset();
    for (int b = 0; b < 3; b++) rchk("R12 mask restored", ba(b, 4), 32'hFFFF_FFFF);
    rchk("R12 cfg cleared", 12'h10C, 32'h0);
    rchk("R12 autoidle cleared", 12'h010, 32'h0);
    rchk("R12 idle cleared", 12'h050, 32'h0);
    rchk("R12 vector cleared", 12'h040, 32'h0);
    chk("R12 irq low", 32'(irq_o), 32'h0);
    chk("R12 fiq low", 32'(fiq_o), 32'h0);
    check_banks(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule